// File: doc/BRIEF.md
# Single-Precision Sign-Injection, Classify and Move Unit

This unit executes the single-precision sign-manipulation, classification and FP-to-integer move operations of a 64-bit floating-point datapath. Each cycle it takes two 64-bit FP register operands and an operation code. One clock edge later it presents either a 64-bit FP result or a 64-bit integer result. The result port that the operation does not use reads zero.

FP registers hold single-precision values in NaN-boxed form. Every operation except the move checks that the upper word of each operand is all ones. An operand that fails the check is replaced by the canonical single-precision NaN before use. Every FP result is written back NaN-boxed. Negate, absolute value and plain register copy are not separate operations: they are the sign-injection forms with both operands set to the same register.

Top module: `sfp_sgn_cls_mv`

## Requirements
- R1: While `rst_n` is low at a rising edge, both `fp_res` and `int_res` become zero.
- R2: Results are registered and appear after the rising edge that samples the inputs. `op_sel` selects the operation: 0 is sign inject, 1 is sign inject negated, 2 is sign inject XOR, 3 is classify and 4 is move to integer. For codes 0–2, `int_res` is zero. For codes 3–4, `fp_res` is zero. Codes 5–7 drive both results to zero.
- R3: For codes 0–3, an operand whose bits 63:32 are not all ones is used as the value 0x7FC00000.
- R4: Sign inject gives bits 63:32 all ones, bit 31 equal to operand B's bit 31, and bits 30:0 from operand A.
- R5: Sign inject negated works like R4, but bit 31 is the inverse of operand B's bit 31.
- R6: Sign inject XOR works like R4, but bit 31 is the XOR of bit 31 of A and bit 31 of B.
- R7: Sign injection copies the exponent and mantissa of a NaN in operand A unchanged, whether the NaN is quiet or signaling.
- R8: Classify returns a one-hot mask in bits 9:0 of `int_res`, with bits 63:10 zero. The bit meanings are: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN.
- R9: For classify, a NaN with mantissa bit 22 set is quiet. A NaN with bit 22 clear and a nonzero mantissa is signaling.
- R10: Move to integer gives operand A's bits 31:0, sign-extended from bit 31 to 64 bits. No NaN-box check is applied, so bits 63:32 of A have no effect.
- R11: With both operands equal, codes 1, 2 and 0 act as negate, absolute value and copy of the boxed value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation code (see R2) |
| src_a | input | 64 | FP operand A |
| src_b | input | 64 | FP operand B |
| fp_res | output | 64 | NaN-boxed FP result |
| int_res | output | 64 | Integer result (classify mask or moved bits) |

## Verification
The bench drives operands whose upper word is not all ones into sign-inject XOR and into classify. A unit that reads the register as double precision would return the raw bits, or classify the value as a positive normal together with a quiet NaN. It checks the XOR sign with a negative B and a positive A, which exposes a unit that takes bit 63 as the sign instead of bit 31. Classify is swept across all ten classes, and both NaN kinds are sent through sign injection, so a swapped mask bit or a corrupted payload shows up. Move is given an unboxed word with bit 31 set, which catches both a missing sign extension and a NaN-box check that does not belong there.

// File: rtl/sfp_pkg.sv
// Shared constants and types for the single-precision sign/class/move unit.
// Assumes IEEE-754 binary32 format held in the low word of a wider register.
package sfp_pkg;
    localparam int SP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int MANT_W  = 23;
    localparam int CLS_W   = 10;
    localparam logic [SP_W-1:0] SP_CANON_NAN = 32'h7FC0_0000;

    typedef enum logic [2:0] {
        OP_SGNJ  = 3'd0,
        OP_SGNJN = 3'd1,
        OP_SGNJX = 3'd2,
        OP_CLASS = 3'd3,
        OP_MVX   = 3'd4
    } sfp_op_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } sp_t;
endpackage

// File: rtl/sfp_unbox.sv
// Extracts a single-precision value from a wide FP register.
// Assumes a properly boxed value has every bit above SP_W set; otherwise
// the canonical NaN is substituted.
module sfp_unbox
    import sfp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] reg_val,
    output sp_t             sp_val
);
    localparam int HI_W = XLEN - SP_W;

    logic boxed;

    // Purpose: test the upper word and choose the raw or canonical value.
    always_comb begin
        boxed  = &reg_val[XLEN-1:SP_W];
        sp_val = boxed ? sp_t'(reg_val[SP_W-1:0]) : sp_t'(SP_CANON_NAN);
    end

    logic [HI_W-1:0] unused_hi_w;
    assign unused_hi_w = '0;
endmodule

// File: rtl/sfp_sign_inject.sv
// Sign injection: exponent and mantissa come from operand A, and the sign
// comes from B, from inverted B, or from A XOR B. The result is NaN-boxed to XLEN.
// Assumes both operands are already unboxed.
module sfp_sign_inject
    import sfp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  sfp_op_e         mode,
    input  sp_t             op_a,
    input  sp_t             op_b,
    output logic [XLEN-1:0] result
);
    logic new_sign;

    // Purpose: pick the injected sign for the selected form.
    always_comb begin
        case (mode)
            OP_SGNJ:  new_sign = op_b.sign;
            OP_SGNJN: new_sign = ~op_b.sign;
            OP_SGNJX: new_sign = op_a.sign ^ op_b.sign;
            default:  new_sign = op_a.sign;
        endcase
    end

    // Purpose: rebuild the value with the new sign and box it.
    always_comb begin
        result = {{(XLEN-SP_W){1'b1}}, new_sign, op_a.expo, op_a.mant};
    end
endmodule

// File: rtl/sfp_classify.sv
// Classifies a single-precision value into a one-hot class mask.
// Assumes the input is already unboxed.
module sfp_classify
    import sfp_pkg::*;
(
    input  sp_t              val,
    output logic [CLS_W-1:0] mask
);
    logic exp_ones, exp_zero, mant_zero;
    logic is_inf, is_nan, is_zero, is_sub, is_norm;

    // Purpose: decode the exponent and mantissa into categories.
    always_comb begin
        exp_ones  = &val.expo;
        exp_zero  = ~|val.expo;
        mant_zero = ~|val.mant;
        is_inf    = exp_ones & mant_zero;
        is_nan    = exp_ones & ~mant_zero;
        is_zero   = exp_zero & mant_zero;
        is_sub    = exp_zero & ~mant_zero;
        is_norm   = ~exp_ones & ~exp_zero;
    end

    // Purpose: build the class mask with sign splitting.
    always_comb begin
        mask    = '0;
        mask[0] = val.sign & is_inf;
        mask[1] = val.sign & is_norm;
        mask[2] = val.sign & is_sub;
        mask[3] = val.sign & is_zero;
        mask[4] = ~val.sign & is_zero;
        mask[5] = ~val.sign & is_sub;
        mask[6] = ~val.sign & is_norm;
        mask[7] = ~val.sign & is_inf;
        mask[8] = is_nan & ~val.mant[MANT_W-1];
        mask[9] = is_nan & val.mant[MANT_W-1];
    end
endmodule

// File: rtl/sfp_sgn_cls_mv.sv
// Top of the single-precision sign-injection, classify and move unit.
// Latency is one cycle. FP results are NaN-boxed. The move path uses the
// raw low word of A. Reset is synchronous and active low.
module sfp_sgn_cls_mv
    import sfp_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NOPS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_sel,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] fp_res,
    output logic [XLEN-1:0] int_res
);
    localparam int HI_W = XLEN - SP_W;

    logic [NOPS-1:0][XLEN-1:0] raw_ops;
    sp_t  [NOPS-1:0]           sp_ops;
    logic [XLEN-1:0]           inj_res;
    logic [CLS_W-1:0]          cls_mask;
    logic [XLEN-1:0]           fp_d, int_d;
    sfp_op_e                   op_e;

    assign raw_ops = {src_b, src_a};
    assign op_e    = sfp_op_e'(op_sel);

    // One unboxing stage for each source operand.
    for (genvar g = 0; g < NOPS; g++) begin : g_unbox
        sfp_unbox #(.XLEN(XLEN)) i_unbox (
            .reg_val (raw_ops[g]),
            .sp_val  (sp_ops[g])
        );
    end

    sfp_sign_inject #(.XLEN(XLEN)) i_inject (
        .mode   (op_e),
        .op_a   (sp_ops[0]),
        .op_b   (sp_ops[1]),
        .result (inj_res)
    );

    sfp_classify i_classify (
        .val  (sp_ops[0]),
        .mask (cls_mask)
    );

    // Purpose: route the selected operation to the proper result port.
    always_comb begin
        fp_d  = '0;
        int_d = '0;
        case (op_sel)
            3'd0, 3'd1, 3'd2: fp_d  = inj_res;
            3'd3:             int_d = {{(XLEN-CLS_W){1'b0}}, cls_mask};
            3'd4:             int_d = {{HI_W{src_a[SP_W-1]}}, src_a[SP_W-1:0]};
            default: ;
        endcase
    end

    // Purpose: register the results, with a synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_res  <= '0;
            int_res <= '0;
        end else begin
            fp_res  <= fp_d;
            int_res <= int_d;
        end
    end

    // R4 R5 R6: every sign-injection result is NaN-boxed.
    a_r4_fp_boxed: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) <= 3'd2) |-> (&fp_res[XLEN-1:SP_W]));

    // R3: an unboxed A given to sign-inject XOR keeps the canonical NaN magnitude.
    a_r3_canon_nan: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd2 && !(&$past(src_a[XLEN-1:SP_W])))
        |-> (fp_res[SP_W-2:0] == SP_CANON_NAN[SP_W-2:0]));

    // R8: the class mask is one-hot and zero-extended.
    a_r8_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd3)
        |-> ($countones(int_res) == 1 && int_res[XLEN-1:CLS_W] == '0));

    // R10: the moved word is sign-extended from bit 31.
    a_r10_sext: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 3'd4)
        |-> (int_res[XLEN-1:SP_W] == {HI_W{int_res[SP_W-1]}}));

    // R2: the two result ports are never nonzero at the same time.
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !((|fp_res) && (|int_res)));
endmodule

// File: tb/test_sfp_sgn_cls_mv.sv
// Directed bench for sfp_sgn_cls_mv. One task per scenario; each task checks its own results.
module test_sfp_sgn_cls_mv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [63:0] src_a = '0, src_b = '0;
    logic [63:0] fp_res, int_res;
    int          n_checks = 0, n_errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    sfp_sgn_cls_mv i_sfp_sgn_cls_mv (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .fp_res(fp_res), .int_res(int_res)
    );

    function automatic logic [63:0] box(input logic [31:0] v);
        return {32'hFFFF_FFFF, v};
    endfunction

    // Reference: the value of a register as seen by single-precision ops.
    function automatic logic [31:0] ref_unbox(input logic [63:0] r);
        if (r[63:32] == 32'hFFFF_FFFF) return r[31:0];
        return 32'h7FC0_0000;
    endfunction

    // Reference class mask, worked out from the category definitions.
    function automatic logic [63:0] ref_class(input logic [31:0] v);
        logic s; logic [7:0] e; logic [22:0] m; int idx;
        s = v[31]; e = v[30:23]; m = v[22:0];
        if (e == 8'hFF && m != 0) idx = m[22] ? 9 : 8;
        else if (e == 8'hFF)      idx = s ? 0 : 7;
        else if (e == 0 && m == 0) idx = s ? 3 : 4;
        else if (e == 0)          idx = s ? 2 : 5;
        else                      idx = s ? 1 : 6;
        return 64'd1 << idx;
    endfunction

    // Reference model of the whole unit.
    task automatic ref_model(input logic [2:0] op, input logic [63:0] a, b,
                             output logic [63:0] efp, eint);
        logic [31:0] ua, ub; logic sg;
        ua = ref_unbox(a); ub = ref_unbox(b);
        efp = '0; eint = '0;
        case (op)
            3'd0: begin sg = ub[31];          efp = box({sg, ua[30:0]}); end
            3'd1: begin sg = !ub[31];         efp = box({sg, ua[30:0]}); end
            3'd2: begin sg = ua[31] != ub[31]; efp = box({sg, ua[30:0]}); end
            3'd3: eint = ref_class(ua);
            3'd4: eint = {{32{a[31]}}, a[31:0]};
            default: ;
        endcase
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%016h expected 0x%016h", req, what, act, exp);
        end
    endtask

    // Apply one operation and compare both ports one edge later.
    task automatic run_op(input string req, input logic [2:0] op,
                          input logic [63:0] a, b);
        logic [63:0] efp, eint;
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b;
        @(posedge clk); #1;
        ref_model(op, a, b, efp, eint);
        check(req, "fp_res", fp_res, efp);
        check(req, "int_res", int_res, eint);
    endtask

    task automatic t_reset();  // R1
        @(negedge clk);
        rst_n = 1'b0; op_sel = 3'd4; src_a = 64'hFFFF_FFFF;
        @(posedge clk); #1;
        check("R1", "fp_res in reset", fp_res, '0);
        check("R1", "int_res in reset", int_res, '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_sign_forms();  // R4 R5 R6
        run_op("R4", 3'd0, box(32'h3F80_0000), box(32'h8000_0000));
        run_op("R4", 3'd0, box(32'hC040_0000), box(32'h0000_0001));
        run_op("R5", 3'd1, box(32'h3F80_0000), box(32'h8000_0000));
        run_op("R5", 3'd1, box(32'h3F80_0000), box(32'h0000_0000));
        run_op("R6", 3'd2, box(32'h7B37_54EF), box(32'h8000_0000));
        run_op("R6", 3'd2, box(32'hFB37_54EF), box(32'h8123_4567));
        check("R6", "xor sign literal", fp_res, 64'hFFFF_FFFF_7B37_54EF);
    endtask

    task automatic t_unboxed();  // R3
        run_op("R3", 3'd2, 64'hCFA6_95B1_0475_53B1, box(32'h1234_5678));
        check("R3", "canon nan xor", fp_res, 64'hFFFF_FFFF_7FC0_0000);
        run_op("R3", 3'd0, box(32'h4000_0000), 64'h0000_0000_8000_0000);
        check("R3", "unboxed B sign", fp_res, 64'hFFFF_FFFF_4000_0000);
        run_op("R3", 3'd3, 64'h7FEF_FFFF_FFFF_FFFF, '0);
        check("R3", "classify unboxed", int_res, 64'h200);
    endtask

    task automatic t_nan_payload();  // R7
        run_op("R7", 3'd1, box(32'h7F80_0123), box(32'h0000_0000));
        check("R7", "snan payload", fp_res, 64'hFFFF_FFFF_FF80_0123);
        run_op("R7", 3'd0, box(32'hFFC5_5555), box(32'h0000_0000));
        check("R7", "qnan payload", fp_res, 64'hFFFF_FFFF_7FC5_5555);
    endtask

    task automatic t_classify();  // R8 R9
        logic [31:0] vals [10] = '{32'hFF80_0000, 32'hBF80_0000, 32'h8000_0001,
            32'h8000_0000, 32'h0000_0000, 32'h0040_0000, 32'h3F80_0000,
            32'h7F80_0000, 32'h7FBF_FFFF, 32'h7FC0_0001};
        for (int i = 0; i < 10; i++) begin
            run_op("R8", 3'd3, box(vals[i]), '0);
            check("R8", "class bit", int_res, 64'd1 << i);
        end
        run_op("R9", 3'd3, box(32'hFF80_0001), '0);
        check("R9", "neg snan", int_res, 64'h100);
        run_op("R9", 3'd3, box(32'hFFC0_0000), '0);
        check("R9", "neg qnan", int_res, 64'h200);
    endtask

    task automatic t_move();  // R10
        run_op("R10", 3'd4, 64'h0000_0000_FFFF_FFFF, '0);
        check("R10", "sext ones", int_res, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R10", 3'd4, 64'hFFFF_FFFF_7FFF_0001, '0);
        check("R10", "positive word", int_res, 64'h0000_0000_7FFF_0001);
        run_op("R10", 3'd4, 64'h1234_5678_8000_0000, '0);
        check("R10", "unboxed neg", int_res, 64'hFFFF_FFFF_8000_0000);
    endtask

    task automatic t_aliases();  // R11
        run_op("R11", 3'd1, box(32'h4049_0FDB), box(32'h4049_0FDB));
        check("R11", "negate", fp_res, 64'hFFFF_FFFF_C049_0FDB);
        run_op("R11", 3'd2, box(32'hC049_0FDB), box(32'hC049_0FDB));
        check("R11", "abs", fp_res, 64'hFFFF_FFFF_4049_0FDB);
        run_op("R11", 3'd0, box(32'hC049_0FDB), box(32'hC049_0FDB));
        check("R11", "copy", fp_res, 64'hFFFF_FFFF_C049_0FDB);
    endtask

    task automatic t_opcodes();  // R2
        for (int op = 5; op < 8; op++) begin
            run_op("R2", 3'(op), box(32'hBF80_0000), box(32'h8000_0000));
            check("R2", "unused code fp", fp_res, '0);
            check("R2", "unused code int", int_res, '0);
        end
    endtask

    initial begin
        t_reset();
        t_sign_forms();
        t_unboxed();
        t_nan_payload();
        t_classify();
        t_move();
        t_aliases();
        t_opcodes();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule